// File: doc/BRIEF.md
# Pad Pull Resistor Control Registers

This block holds the pull-up and pull-down settings for a group of I/O pads. Software reaches it through a simple register port: one write strobe and one read strobe, each taking a single cycle, with an address and a data word that has one bit per pad. Each resistor type has three addresses. Writing a 1 to a bit of its enable address turns the resistor on for that pad. Writing a 1 to a bit of its disable address turns it off. Its status address can only be read.

Both status registers use inverted polarity: a status bit of 1 means the resistor is off. The block drives one pull-up enable and one pull-down enable per pad, and the two are never on together. A request to turn a resistor on is dropped, one pad at a time, while the opposite resistor on that pad is still on. Other pads in the same write are still updated. Pull-up control does not depend on the pad's GPIO or peripheral mode, so the block has no mode input.

Word addresses are as follows: 0 is pull-up enable, 1 is pull-up disable, 2 is pull-up status, 3 is pull-down enable, 4 is pull-down disable, 5 is pull-down status, and 6 and 7 are unused.

Top module: `pad_pull_ctrl`

## Requirements
- R1: After reset, every pull-up is on and every pull-down is off. `pu_en` is all ones, `pd_en` is all zeros, pull-up status (address 2) reads 0 and pull-down status (address 5) reads all ones.
- R2: A write to address 0 turns on the pull-up of every pad whose data bit is 1 and whose pull-down is off. `pu_en` changes on that clock edge.
- R3: A write to address 1 turns off the pull-up of every pad whose data bit is 1, with no condition.
- R4: A write to address 3 turns on the pull-down of every pad whose data bit is 1 and whose pull-up is off. A write to address 4 turns off the pull-down of every pad whose data bit is 1.
- R5: For a pad whose pull-up is on, a write to address 3 leaves that pad unchanged. Other pads in the same word are still updated.
- R6: For a pad whose pull-down is on, a write to address 0 leaves that pad unchanged. Other pads in the same word are still updated.
- R7: Data bits written as 0 change nothing. Writes to the status addresses (2, 5) or to the unused addresses (6, 7) change nothing.
- R8: With `rd_en` high, address 2 returns the inverse of `pu_en` and address 5 returns the inverse of `pd_en` (1 = off). Every other address returns 0. With `rd_en` low, `rdata` is 0.
- R9: On every pad, `pu_en` and `pd_en` are never 1 at the same time.
- R10: A read does not change any resistor setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Read strobe; `rdata` is valid in the same cycle |
| addr | input | AW (3) | Word address of the register |
| wdata | input | NPINS (32) | Write data, one bit per pad |
| rdata | output | NPINS (32) | Read data, one bit per pad |
| pu_en | output | NPINS (32) | Pull-up enable to each pad, 1 = on |
| pd_en | output | NPINS (32) | Pull-down enable to each pad, 1 = on |

## Verification
The assertions assume at most one access per cycle and assume `addr` and `wdata` are known whenever a strobe is high. Under those conditions, the next-state properties compare the pad outputs with their value one cycle earlier. The bench keeps to these conditions: it drives every input on the falling edge, never raises both strobes together, and holds `addr` and `wdata` at defined values throughout. The long pseudo-random phase deliberately mixes enable and disable words that overlap pads already held by the opposite resistor. This exercises the per-pad drop rule in both directions.

// File: rtl/pad_pull_pkg.sv
// Package: shared address map and strobe bundle for the pad pull control bank.
// Assumes word addressing; only the low AW address bits are decoded.
package pad_pull_pkg;
    localparam int unsigned ADR_PU_ON   = 0;
    localparam int unsigned ADR_PU_OFF  = 1;
    localparam int unsigned ADR_PU_STAT = 2;
    localparam int unsigned ADR_PD_ON   = 3;
    localparam int unsigned ADR_PD_OFF  = 4;
    localparam int unsigned ADR_PD_STAT = 5;

    typedef struct packed {
        logic pu_on;
        logic pu_off;
        logic pd_on;
        logic pd_off;
    } pull_stb_t;
endpackage

// File: rtl/pad_pull_decode.sv
// Module: turns a write strobe and an address into one strobe per action register.
// Assumes at most one access per cycle; unmapped or read-only addresses give no strobe.
module pad_pull_decode
    import pad_pull_pkg::*;
#(
    parameter int unsigned AW = 3
) (
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    output pull_stb_t     stb
);
    // Decode the write address into one-hot action strobes.
    always_comb begin
        stb        = '0;
        stb.pu_on  = wr_en && (addr == AW'(ADR_PU_ON));
        stb.pu_off = wr_en && (addr == AW'(ADR_PU_OFF));
        stb.pd_on  = wr_en && (addr == AW'(ADR_PD_ON));
        stb.pd_off = wr_en && (addr == AW'(ADR_PD_OFF));
    end
endmodule

// File: rtl/pad_pull_lane.sv
// Module: status storage for one resistor type across all pads (1 = off).
// An enable bit takes effect only where the opposite resistor is off (other_on low);
// a disable bit always takes effect. Zero data bits leave status unchanged.
module pad_pull_lane #(
    parameter int unsigned NPINS   = 32,
    parameter bit          RST_OFF = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             on_stb,
    input  logic             off_stb,
    input  logic [NPINS-1:0] wdata,
    input  logic [NPINS-1:0] other_on,
    output logic [NPINS-1:0] stat_off
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic grant_on;

        // Per-pad acceptance of an enable request under the exclusion rule.
        always_comb grant_on = on_stb && wdata[i] && !other_on[i];

        // Per-pad status flop with synchronous active-low reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stat_off[i] <= RST_OFF;
            else if (grant_on)
                stat_off[i] <= 1'b0;
            else if (off_stb && wdata[i])
                stat_off[i] <= 1'b1;
        end
    end
endmodule

// File: rtl/pad_pull_rdmux.sv
// Module: read-data multiplexer; only the two status addresses return data.
// Assumes rdata is sampled in the same cycle as rd_en.
module pad_pull_rdmux
    import pad_pull_pkg::*;
#(
    parameter int unsigned NPINS = 32,
    parameter int unsigned AW    = 3
) (
    input  logic             rd_en,
    input  logic [AW-1:0]    addr,
    input  logic [NPINS-1:0] pu_off,
    input  logic [NPINS-1:0] pd_off,
    output logic [NPINS-1:0] rdata
);
    // Select the status word for a read; everything else returns zero.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == AW'(ADR_PU_STAT))
                rdata = pu_off;
            else if (addr == AW'(ADR_PD_STAT))
                rdata = pd_off;
        end
    end
endmodule

// File: rtl/pad_pull_ctrl.sv
// Module: top of the pad pull-up/pull-down control bank.
// Ties the decode, two status lanes and read mux together; pad enables are the
// inverse of the status flops, so they change on the write clock edge.
module pad_pull_ctrl
    import pad_pull_pkg::*;
#(
    parameter int unsigned NPINS = 32,
    parameter int unsigned AW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [AW-1:0]    addr,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] rdata,
    output logic [NPINS-1:0] pu_en,
    output logic [NPINS-1:0] pd_en
);
    pull_stb_t        stb;
    logic [NPINS-1:0] pu_off;
    logic [NPINS-1:0] pd_off;

    pad_pull_decode #(.AW(AW)) u_dec (
        .wr_en (wr_en),
        .addr  (addr),
        .stb   (stb)
    );

    pad_pull_lane #(.NPINS(NPINS), .RST_OFF(1'b0)) u_pu (
        .clk      (clk),
        .rst_n    (rst_n),
        .on_stb   (stb.pu_on),
        .off_stb  (stb.pu_off),
        .wdata    (wdata),
        .other_on (pd_en),
        .stat_off (pu_off)
    );

    pad_pull_lane #(.NPINS(NPINS), .RST_OFF(1'b1)) u_pd (
        .clk      (clk),
        .rst_n    (rst_n),
        .on_stb   (stb.pd_on),
        .off_stb  (stb.pd_off),
        .wdata    (wdata),
        .other_on (pu_en),
        .stat_off (pd_off)
    );

    pad_pull_rdmux #(.NPINS(NPINS), .AW(AW)) u_rd (
        .rd_en  (rd_en),
        .addr   (addr),
        .pu_off (pu_off),
        .pd_off (pd_off),
        .rdata  (rdata)
    );

    // Drive the pad enables as the inverse of the stored status.
    always_comb begin
        pu_en = ~pu_off;
        pd_en = ~pd_off;
    end
endmodule

// File: rtl/pad_pull_ctrl_chk.sv
// Checker: port-level properties of the pad pull control bank, bound to the top.
// Assumes one access per cycle and known addr/wdata while a strobe is high.
module pad_pull_ctrl_chk #(
    parameter int unsigned NPINS = 32,
    parameter int unsigned AW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic [AW-1:0]    addr,
    input logic [NPINS-1:0] wdata,
    input logic [NPINS-1:0] rdata,
    input logic [NPINS-1:0] pu_en,
    input logic [NPINS-1:0] pd_en
);
    // R9: never both resistors on one pad
    assert_no_conflict_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pu_en & pd_en) == '0);

    // R2/R6: pull-up enable is accepted only where the pull-down is off
    assert_pu_on_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(0)) |=>
        (pu_en == ($past(pu_en) | ($past(wdata) & ~$past(pd_en)))) && $stable(pd_en));

    // R4/R5: pull-down enable is accepted only where the pull-up is off
    assert_pd_on_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(3)) |=>
        (pd_en == ($past(pd_en) | ($past(wdata) & ~$past(pu_en)))) && $stable(pu_en));

    // R3: pull-up disable clears exactly the written bits
    assert_pu_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(1)) |=> pu_en == ($past(pu_en) & ~$past(wdata)));

    // R10: no write, no change
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pu_en) && $stable(pd_en));

    // R8: write-only and unused addresses read as zero
    assert_wo_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr != AW'(2) && addr != AW'(5)) |-> rdata == '0);
endmodule

bind pad_pull_ctrl pad_pull_ctrl_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .pu_en (pu_en),
    .pd_en (pd_en)
);

// File: tb/tb_pad_pull_ctrl.sv
// Bench: behavioural per-pad reference model, compared against the pad outputs on every clock.
module tb_pad_pull_ctrl;
    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [2:0]    addr = '0;
    logic [NP-1:0] wdata = '0;
    logic [NP-1:0] rdata;
    logic [NP-1:0] pu_en;
    logic [NP-1:0] pd_en;

    int  n_chk = 0;
    int  n_err = 0;
    bit  live = 1'b0;
    bit  done = 1'b0;
    bit  model_pu [NP];
    bit  model_pd [NP];
    logic [31:0] lfsr = 32'hACE1_2469;

    pad_pull_ctrl #(.NPINS(NP), .AW(3)) dut (
        .clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata, .pu_en, .pd_en
    );

    always #10 clk = ~clk;

    function automatic logic [NP-1:0] pack(input bit v [NP]);
        logic [NP-1:0] r;
        for (int i = 0; i < NP; i++) r[i] = v[i];
        return r;
    endfunction

    task automatic check(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NP; i++) begin
            model_pu[i] = 1'b1;
            model_pd[i] = 1'b0;
        end
    endtask

    // Behavioural update of the reference for one write.
    task automatic model_write(input int a, input logic [NP-1:0] d);
        for (int i = 0; i < NP; i++) begin
            if (d[i]) begin
                case (a)
                    0: if (!model_pd[i]) model_pu[i] = 1'b1;
                    1: model_pu[i] = 1'b0;
                    3: if (!model_pu[i]) model_pd[i] = 1'b1;
                    4: model_pd[i] = 1'b0;
                    default: ;
                endcase
            end
        end
    endtask

    task automatic do_write(input int a, input logic [NP-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 3'(a); wdata = d;
        @(posedge clk);
        model_write(a, d);
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic do_read(input int a, input logic [NP-1:0] exp, input string req);
        @(negedge clk);
        rd_en = 1'b1; addr = 3'(a);
        #1 check(req, rdata, exp);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Every-clock comparison of pad outputs against the model (R9 covers exclusion).
    always @(negedge clk) begin
        if (live && rst_n) begin
            check("R2/R4 pu_en", pu_en, pack(model_pu));
            check("R2/R4 pd_en", pd_en, pack(model_pd));
            check("R9 exclusion", pu_en & pd_en, '0);
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        check("R1 pu_en", pu_en, '1);
        check("R1 pd_en", pd_en, '0);
        do_read(2, 32'h0000_0000, "R1 pu status");
        do_read(5, 32'hFFFF_FFFF, "R1 pd status");
        live = 1'b1;

        // R5: pull-down request on pads whose pull-up is on is dropped
        do_write(3, 32'hFFFF_0000);
        @(negedge clk); check("R5 drop all", pd_en, 32'h0);
        // R3: pull-up off
        do_write(1, 32'h0000_FF00);
        @(negedge clk); check("R3 pu off", pu_en, 32'hFFFF_00FF);
        // R4/R5: partial acceptance in one word
        do_write(3, 32'h00FF_FFFF);
        @(negedge clk); check("R5 per-pad", pd_en, 32'h0000_FF00);
        // R6: pull-up request dropped where pull-down is on
        do_write(0, 32'h0000_F0F0);
        @(negedge clk); check("R6 drop", pu_en, 32'hFFFF_00FF);
        // R4: pull-down off
        do_write(4, 32'h0000_0F00);
        @(negedge clk); check("R4 pd off", pd_en, 32'h0000_F000);
        // R2: pull-up on now accepted
        do_write(0, 32'h0000_0F00);
        @(negedge clk); check("R2 pu on", pu_en, 32'hFFFF_0FFF);
        // R7: zero data and non-action addresses change nothing
        for (int a = 0; a < 8; a++) do_write(a, 32'h0);
        do_write(2, 32'hFFFF_FFFF);
        do_write(5, 32'hFFFF_FFFF);
        do_write(6, 32'hFFFF_FFFF);
        do_write(7, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R7 pu hold", pu_en, 32'hFFFF_0FFF);
        check("R7 pd hold", pd_en, 32'h0000_F000);
        // R8: status reads and zero reads
        do_read(2, 32'h0000_F000, "R8 pu status");
        do_read(5, 32'hFFFF_0FFF, "R8 pd status");
        for (int a = 0; a < 8; a++)
            if (a != 2 && a != 5) do_read(a, 32'h0, "R8 write-only read");
        @(negedge clk); rd_en = 1'b0; addr = 3'd2;
        #1 check("R8 no strobe", rdata, 32'h0);
        // R10: reads leave state alone
        @(negedge clk);
        check("R10 pu", pu_en, 32'hFFFF_0FFF);
        check("R10 pd", pd_en, 32'h0000_F000);

        // Pseudo-random mix of all addresses
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (k % 5 == 4)
                do_read(lfsr[0] ? 2 : 5,
                        lfsr[0] ? ~pack(model_pu) : ~pack(model_pd), "R8 random read");
            else
                do_write(int'(lfsr[2:0]), lfsr ^ {lfsr[15:0], lfsr[31:16]});
        end

        // R1: reset again mid-run
        @(negedge clk); live = 1'b0; rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; model_reset();
        check("R1 re-reset pu", pu_en, '1);
        check("R1 re-reset pd", pd_en, '0);
        live = 1'b1;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule